// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block runs single read and write cycles on an external asynchronous SRAM-style bus with four chip-select banks. A host presents one command at a time: bank, address, write data and direction. The host holds `req_valid` until a one-cycle `req_ack` marks the end of the cycle. For reads, the sampled data appears on `rsp_rdata` in the acknowledge cycle.

Each access runs through three phases: address setup, data phase and data hold. On the memory side, chip select, write enable and output enable are active low. The data bus drive enable is active high. Each bank has two programmable timing words, one for reads and one for writes.

- Reads always use the bank's read word.
- Writes use the write word only when the bank's extended bit is set. Otherwise they use the read word.

After every access, a turnaround gap with chip select high is enforced before the next access to the same bank, whatever the directions of the two accesses. A request to a different bank may start right away.

Top module: `asram_seq`

## Requirements
- R1: After reset, all chip selects, `mem_we_n` and `mem_oe_n` are high, and `mem_dout_en` and `req_ack` are low.
- R2: An access keeps its bank's chip select low for A+D+H cycles, where A = max(setup field,1), D = max(data field,1) and H = hold field + 1. On a write, `mem_we_n` is low for exactly D cycles, starting after the first A cycles.
- R3: On a write, `mem_dout_en` is high for D+H cycles and `mem_dout` equals the request data throughout. `mem_addr` is constant while chip select is low.
- R4: On a read, `mem_oe_n` is low for D cycles, while `mem_we_n` stays high and `mem_dout_en` stays low. `rsp_rdata` holds `mem_din` as sampled in the last data-phase cycle, and is valid with `req_ack`.
- R5: The hold length is the 2-bit field value plus one clock (bits 31:30 of a timing word), from 1 up to 4 clocks.
- R6: When two consecutive accesses go to the same bank, chip select stays high between them for turnaround field + 1 cycles (bits 19:16 of the first access's timing word). This holds for all four direction pairs.
- R7: When the next access goes to a different bank, it can start one cycle after `req_ack`, so chip select is high for a single cycle.
- R8: A write uses the bank's write timing word only when that bank's extended bit (control word bit 0) is set; otherwise it uses the read word. Reads always use the read word.
- R9: Both timing words of every bank reset to 0x0FFFFFFF. The field positions are: setup at bits 3:0, data phase at bits 15:8, hold at bits 31:30 and turnaround at bits 19:16. At reset this gives a 271-cycle access, with write enable low for 255 cycles.
- R10: At most one chip select is low at any time. `req_ack` is a single-cycle pulse, issued once per access.
- R11: A configuration write uses `cfg_kind` to pick its target: 0 is control, 1 is the read timing word, 2 is the write timing word. A write with `cfg_kind` = 3 changes nothing. Bits 29:20 and 7:4 of a timing word do not affect timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_bank | input | BW | Bank targeted by the configuration write |
| cfg_kind | input | 2 | 0 control, 1 read timing, 2 write timing, 3 none |
| cfg_wdata | input | 32 | Configuration word |
| req_valid | input | 1 | Command present; held until acknowledge |
| req_bank | input | BW | Command bank |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | AW | Command address |
| req_wdata | input | DW | Write data |
| req_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Read data, valid with acknowledge |
| mem_cs_n | output | NBANK | Active-low chip selects |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_addr | output | AW | Memory address |
| mem_dout | output | DW | Write data to memory |
| mem_dout_en | output | 1 | Data bus drive enable |
| mem_din | input | DW | Read data from memory |

## Verification
A phase counter that loads a wrong length shows up as a chip-select low window of the wrong width. This is visible as soon as the access acknowledges, and it also shifts the position of the write strobe inside the window. A stale timing selection shows up at the first write after the extended bit changes. A wrong remembered bank or turnaround count only appears at the next chip-select fall, as a gap that is wrong in width. That is why the tests chain commands back to back and measure every gap.

// File: rtl/asq_pkg.sv
package asq_pkg;
  localparam int ASQ_SW = 4;   // setup field width
  localparam int ASQ_DSW = 8;  // data phase field width
  localparam int ASQ_HW = 2;   // hold field width
  localparam int ASQ_TW = 4;   // turnaround field width
  localparam int ASQ_CW = ASQ_DSW; // phase counter width
  localparam logic [31:0] ASQ_TIM_RST = 32'h0FFF_FFFF;

  localparam logic [1:0] KIND_CTRL = 2'd0;
  localparam logic [1:0] KIND_RTIM = 2'd1;
  localparam logic [1:0] KIND_WTIM = 2'd2;

  typedef struct packed {
    logic [ASQ_HW-1:0]  hold;
    logic [ASQ_TW-1:0]  turn;
    logic [ASQ_DSW-1:0] dset;
    logic [ASQ_SW-1:0]  aset;
  } asq_tim_t;

  typedef enum logic [1:0] {PH_IDLE, PH_ASET, PH_DSET, PH_DHLD} asq_phase_e;

  function automatic asq_tim_t asq_unpack(input logic [31:0] w);
    asq_tim_t t;
    t.hold = w[31:30];
    t.turn = w[19:16];
    t.dset = w[15:8];
    t.aset = w[3:0];
    return t;
  endfunction

  // phase length minus one, with a floor of one clock
  function automatic logic [ASQ_CW-1:0] asq_len_m1(input logic [ASQ_CW-1:0] f);
    return (f == '0) ? '0 : f - 1'b1;
  endfunction
endpackage

// File: rtl/asq_cfg_regs.sv
module asq_cfg_regs
  import asq_pkg::*;
#(
  parameter int NBANK = 4,
  localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1
)(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_we,
  input  logic [BW-1:0]         cfg_bank,
  input  logic [1:0]            cfg_kind,
  input  logic [31:0]           cfg_wdata,
  output asq_tim_t [NBANK-1:0]  rd_tim,
  output asq_tim_t [NBANK-1:0]  wr_tim,
  output logic [NBANK-1:0]      ext_en
);
  // mode, reserved and address-hold bits carry no timing here
  logic cfg_unused_bits;
  assign cfg_unused_bits = ^{cfg_wdata[29:20], cfg_wdata[7:4]};

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit;
    assign hit = cfg_we && (cfg_bank == BW'(b));
    always_ff @(posedge clk) begin
      if (rst) begin
        rd_tim[b] <= asq_unpack(ASQ_TIM_RST);
        wr_tim[b] <= asq_unpack(ASQ_TIM_RST);
        ext_en[b] <= 1'b0;
      end else if (hit) begin
        case (cfg_kind)
          KIND_CTRL: ext_en[b] <= cfg_wdata[0];
          KIND_RTIM: rd_tim[b] <= asq_unpack(cfg_wdata);
          KIND_WTIM: wr_tim[b] <= asq_unpack(cfg_wdata);
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/asq_turn_guard.sv
module asq_turn_guard
  import asq_pkg::*;
#(
  parameter int NBANK = 4,
  localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  logic [BW-1:0]     done_bank,
  input  logic [ASQ_TW-1:0] done_turn,
  input  logic [BW-1:0]     req_bank,
  output logic              blocked
);
  logic [BW-1:0]     last_bank;
  logic [ASQ_TW-1:0] gap_cnt;

  // loading the field value (n) lets a same-bank start land n+1 edges later
  always_ff @(posedge clk) begin
    if (rst) begin
      last_bank <= '0;
      gap_cnt   <= '0;
    end else if (done) begin
      last_bank <= done_bank;
      gap_cnt   <= done_turn;
    end else if (gap_cnt != '0) begin
      gap_cnt <= gap_cnt - 1'b1;
    end
  end

  assign blocked = (gap_cnt != '0) && (req_bank == last_bank);

  AST_GAP_COUNTS_DOWN: assert property (@(posedge clk) disable iff (rst)
    (!done && $past(!done) && gap_cnt != '0) |=> (gap_cnt == $past(gap_cnt) - 1'b1)) else $error("gap counter"); // R6
endmodule

// File: rtl/asq_phase_fsm.sv
module asq_phase_fsm
  import asq_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int AW = 16,
  parameter int DW = 16,
  localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [BW-1:0]     req_bank,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  asq_tim_t          tim,
  input  logic              blocked,
  input  logic [DW-1:0]     mem_din,
  output logic [NBANK-1:0]  cs_n,
  output logic              we_n,
  output logic              oe_n,
  output logic [AW-1:0]     addr,
  output logic [DW-1:0]     dout,
  output logic              dout_en,
  output logic              ack,
  output logic [DW-1:0]     rdata,
  output logic              done,
  output logic [BW-1:0]     done_bank,
  output logic [ASQ_TW-1:0] done_turn
);
  asq_phase_e         ph_q, ph_d;
  logic [ASQ_CW-1:0]  cnt_q, cnt_d;
  logic [BW-1:0]      bank_q, bank_d;
  logic               wr_q, wr_d;
  logic [AW-1:0]      addr_d;
  logic [DW-1:0]      data_d;
  logic [ASQ_DSW-1:0] dset_q, dset_d;
  logic [ASQ_HW-1:0]  hold_q, hold_d;
  logic [ASQ_TW-1:0]  turn_q, turn_d;
  logic               start, last_cnt;
  logic [NBANK-1:0]   cs_d;

  assign start    = (ph_q == PH_IDLE) && req_valid && !blocked;
  assign last_cnt = (cnt_q == '0);

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    bank_d = bank_q;
    wr_d   = wr_q;
    addr_d = addr;
    data_d = dout;
    dset_d = dset_q;
    hold_d = hold_q;
    turn_d = turn_q;
    unique case (ph_q)
      PH_IDLE: if (start) begin
        ph_d   = PH_ASET;
        cnt_d  = asq_len_m1(ASQ_CW'(tim.aset));
        bank_d = req_bank;
        wr_d   = req_write;
        addr_d = req_addr;
        data_d = req_wdata;
        dset_d = tim.dset;
        hold_d = tim.hold;
        turn_d = tim.turn;
      end
      PH_ASET: if (last_cnt) begin
        ph_d  = PH_DSET;
        cnt_d = asq_len_m1(ASQ_CW'(dset_q));
      end else cnt_d = cnt_q - 1'b1;
      PH_DSET: if (last_cnt) begin
        ph_d  = PH_DHLD;
        cnt_d = ASQ_CW'(hold_q);
      end else cnt_d = cnt_q - 1'b1;
      PH_DHLD: if (last_cnt) ph_d = PH_IDLE;
               else cnt_d = cnt_q - 1'b1;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_comb begin
    cs_d = '1;
    if (ph_d != PH_IDLE) cs_d[bank_d] = 1'b0;
  end

  assign done      = (ph_q == PH_DHLD) && last_cnt;
  assign done_bank = bank_q;
  assign done_turn = turn_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      bank_q  <= '0;
      wr_q    <= 1'b0;
      dset_q  <= '0;
      hold_q  <= '0;
      turn_q  <= '0;
      addr    <= '0;
      dout    <= '0;
      cs_n    <= '1;
      we_n    <= 1'b1;
      oe_n    <= 1'b1;
      dout_en <= 1'b0;
      ack     <= 1'b0;
      rdata   <= '0;
    end else begin
      ph_q    <= ph_d;
      cnt_q   <= cnt_d;
      bank_q  <= bank_d;
      wr_q    <= wr_d;
      dset_q  <= dset_d;
      hold_q  <= hold_d;
      turn_q  <= turn_d;
      addr    <= addr_d;
      dout    <= data_d;
      cs_n    <= cs_d;
      we_n    <= !((ph_d == PH_DSET) && wr_d);
      oe_n    <= !((ph_d == PH_DSET) && !wr_d);
      dout_en <= ((ph_d == PH_DSET) || (ph_d == PH_DHLD)) && wr_d;
      ack     <= done;
      if ((ph_q == PH_DSET) && last_cnt && !wr_q) rdata <= mem_din;
    end
  end

  AST_WE_INSIDE_CS: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> !(&cs_n)) else $error("we outside cs"); // R2
  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (rst)
    (we_n || oe_n)) else $error("we and oe both low"); // R4
  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n)) else $error("several cs low"); // R10
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack) else $error("ack longer than one cycle"); // R10
  AST_DOUT_STABLE: assert property (@(posedge clk) disable iff (rst)
    (dout_en && $past(dout_en)) |-> $stable(dout)) else $error("dout moved"); // R3
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!(&cs_n) && !(&$past(cs_n))) |-> $stable(addr)) else $error("addr moved"); // R3
endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asq_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int AW = 16,
  parameter int DW = 16,
  localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [BW-1:0]    cfg_bank,
  input  logic [1:0]       cfg_kind,
  input  logic [31:0]      cfg_wdata,
  input  logic             req_valid,
  input  logic [BW-1:0]    req_bank,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             req_ack,
  output logic [DW-1:0]    rsp_rdata,
  output logic [NBANK-1:0] mem_cs_n,
  output logic             mem_we_n,
  output logic             mem_oe_n,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_dout,
  output logic             mem_dout_en,
  input  logic [DW-1:0]    mem_din
);
  asq_tim_t [NBANK-1:0] rd_tim, wr_tim;
  logic [NBANK-1:0]     ext_en;
  asq_tim_t             sel_tim;
  logic                 blocked, done;
  logic [BW-1:0]        done_bank;
  logic [ASQ_TW-1:0]    done_turn;

  asq_cfg_regs #(.NBANK(NBANK)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_bank(cfg_bank),
    .cfg_kind(cfg_kind), .cfg_wdata(cfg_wdata),
    .rd_tim(rd_tim), .wr_tim(wr_tim), .ext_en(ext_en)
  );

  assign sel_tim = (req_write && ext_en[req_bank]) ? wr_tim[req_bank] : rd_tim[req_bank];

  asq_turn_guard #(.NBANK(NBANK)) u_guard (
    .clk(clk), .rst(rst), .done(done), .done_bank(done_bank),
    .done_turn(done_turn), .req_bank(req_bank), .blocked(blocked)
  );

  asq_phase_fsm #(.NBANK(NBANK), .AW(AW), .DW(DW)) u_fsm (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_bank(req_bank),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .tim(sel_tim), .blocked(blocked), .mem_din(mem_din),
    .cs_n(mem_cs_n), .we_n(mem_we_n), .oe_n(mem_oe_n), .addr(mem_addr),
    .dout(mem_dout), .dout_en(mem_dout_en), .ack(req_ack), .rdata(rsp_rdata),
    .done(done), .done_bank(done_bank), .done_turn(done_turn)
  );

  AST_ACK_AFTER_CS: assert property (@(posedge clk) disable iff (rst)
    req_ack |-> (&mem_cs_n && !(&$past(mem_cs_n)))) else $error("ack not at cs rise"); // R2
endmodule

// File: tb/asram_seq_tb.sv
module asram_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_bank = '0;
  logic [1:0]  cfg_kind = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_bank = '0;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ack;
  logic [15:0] rsp_rdata;
  logic [3:0]  mem_cs_n;
  logic        mem_we_n, mem_oe_n, mem_dout_en;
  logic [15:0] mem_addr, mem_dout, mem_din;

  int tests = 0, fails = 0;
  int m_cs, m_we, m_we_start, m_oe, m_den, m_pre, m_ack, m_bad_bank, m_addr_bad, m_data_bad;
  logic [15:0] m_rd;

  always #10 clk = ~clk;
  assign mem_din = mem_addr ^ 16'h5A3C;

  asram_seq u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_bank(cfg_bank), .cfg_kind(cfg_kind),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_bank(req_bank),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ack(req_ack), .rsp_rdata(rsp_rdata), .mem_cs_n(mem_cs_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr),
    .mem_dout(mem_dout), .mem_dout_en(mem_dout_en), .mem_din(mem_din)
  );

  task automatic chk(input string tag, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] tword(input int hold, input int turn, input int dset, input int aset);
    return {hold[1:0], 2'b00, 8'h00, turn[3:0], dset[7:0], 4'h0, aset[3:0]};
  endfunction

  task automatic cfg(input int bank, input int kind, input logic [31:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_bank = bank[1:0]; cfg_kind = kind[1:0]; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // issue one command and measure it at falling edges until acknowledge
  task automatic access(input int bank, input bit wr, input logic [15:0] a, input logic [15:0] d);
    bit started = 0;
    logic [15:0] a0 = '0;
    m_cs = 0; m_we = 0; m_we_start = -1; m_oe = 0; m_den = 0; m_pre = 0; m_ack = 0;
    m_bad_bank = 0; m_addr_bad = 0; m_data_bad = 0;
    req_bank = bank[1:0]; req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (mem_cs_n != 4'hF) begin
        if (!started) a0 = mem_addr;
        started = 1;
        m_cs++;
        if (mem_cs_n[bank] != 1'b0 || $countones(~mem_cs_n) != 1) m_bad_bank++;
        if (mem_addr != a0 || mem_addr != a) m_addr_bad++;
      end else if (!started) m_pre++;
      if (!mem_we_n) begin
        if (m_we_start < 0) m_we_start = m_cs - 1;
        m_we++;
      end
      if (!mem_oe_n) m_oe++;
      if (mem_dout_en) begin
        m_den++;
        if (mem_dout != d) m_data_bad++;
      end
      if (req_ack) begin
        m_ack++;
        m_rd = rsp_rdata;
        req_valid = 1'b0;
        break;
      end
    end
    if (m_ack == 0) begin
      req_valid = 1'b0;
      chk("R2 access acknowledged", 0, 1);
    end
  endtask

  task automatic t_reset;
    chk("R1 cs_n", mem_cs_n, 4'hF);
    chk("R1 we_n", mem_we_n, 1);
    chk("R1 oe_n", mem_oe_n, 1);
    chk("R1 dout_en", mem_dout_en, 0);
    chk("R1 ack", req_ack, 0);
  endtask

  task automatic t_default_write;
    access(0, 1, 16'h0123, 16'hBEEF);
    chk("R9 default cs length", m_cs, 271);
    chk("R9 default we length", m_we, 255);
    chk("R9 default we start", m_we_start, 15);
    chk("R3 default dout_en length", m_den, 256);
    chk("R3 default data", m_data_bad, 0);
    chk("R10 one bank low", m_bad_bank, 0);
  endtask

  task automatic t_write_no_ext;
    cfg(1, 1, tword(2, 4, 5, 3));
    idle(20);
    access(1, 1, 16'h1111, 16'hA5A5);
    chk("R8 write w/o ext uses read word", m_cs, 11);
    chk("R2 we length", m_we, 5);
    chk("R2 we start", m_we_start, 3);
    chk("R3 dout_en length", m_den, 8);
    chk("R3 address stable", m_addr_bad, 0);
    chk("R3 data", m_data_bad, 0);
    chk("R5 hold field 2", m_cs - 8, 3);
  endtask

  task automatic t_read;
    idle(20);
    access(1, 0, 16'h2345, 16'h0000);
    chk("R4 read cs length", m_cs, 11);
    chk("R4 oe length", m_oe, 5);
    chk("R4 no we", m_we, 0);
    chk("R4 no drive", m_den, 0);
    chk("R4 read data", m_rd, 16'h2345 ^ 16'h5A3C);
  endtask

  task automatic t_ext_write;
    // mode, reserved and address-hold bits set: no timing effect (R11)
    cfg(1, 2, {2'b00, 2'b11, 8'hFF, 4'h2, 8'h00, 4'hF, 4'h0});
    cfg(1, 0, 32'h1);
    idle(20);
    access(1, 1, 16'h3333, 16'h5555);
    chk("R8 ext write uses write word", m_cs, 3);
    chk("R2 zero fields floor we", m_we, 1);
    chk("R2 zero fields floor start", m_we_start, 1);
    chk("R5 hold field 0", m_den, 2);
    chk("R11 ignored bits", m_cs, 3);
    idle(20);
    access(1, 0, 16'h3334, 16'h0);
    chk("R8 read keeps read word", m_cs, 11);
  endtask

  task automatic t_turn_pairs;
    idle(20);
    access(1, 1, 16'h4000, 16'h0001);
    access(1, 1, 16'h4001, 16'h0002);
    chk("R6 write-write gap", m_pre + 1, 3);
    access(1, 0, 16'h4002, 16'h0);
    chk("R6 write-read gap", m_pre + 1, 3);
    access(1, 1, 16'h4003, 16'h0003);
    chk("R6 read-write gap", m_pre + 1, 5);
    access(1, 0, 16'h4004, 16'h0);
    chk("R6 write-read gap 2", m_pre + 1, 3);
    access(1, 0, 16'h4005, 16'h0);
    chk("R6 read-read gap", m_pre + 1, 5);
    chk("R4 read data chained", m_rd, 16'h4005 ^ 16'h5A3C);
  endtask

  task automatic t_cross_bank;
    cfg(2, 1, tword(0, 15, 1, 1));
    idle(20);
    access(1, 1, 16'h5000, 16'h0004);
    access(2, 0, 16'h5001, 16'h0);
    chk("R7 other bank gap", m_pre + 1, 1);
    chk("R7 bank2 cs length", m_cs, 3);
    access(2, 0, 16'h5002, 16'h0);
    chk("R6 max turnaround", m_pre + 1, 16);
    access(1, 0, 16'h5003, 16'h0);
    chk("R7 back to other bank", m_pre + 1, 1);
    chk("R10 one bank low", m_bad_bank, 0);
  endtask

  task automatic t_hold_max;
    cfg(3, 1, tword(3, 0, 1, 2));
    idle(20);
    access(3, 0, 16'h6000, 16'h0);
    chk("R5 hold field 3", m_cs, 7);
    chk("R5 oe with long hold", m_oe, 1);
  endtask

  task automatic t_kind3_ignored;
    cfg(1, 3, 32'h0000_0000);
    idle(20);
    access(1, 1, 16'h7000, 16'h0007);
    chk("R11 kind 3 no effect", m_cs, 3);
    chk("R11 kind 3 ext kept", m_we, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog (all) got=timeout exp=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    idle(2);
    t_reset();
    t_default_write();
    t_write_no_ext();
    t_read();
    t_ext_write();
    t_turn_pairs();
    t_cross_bank();
    t_hold_max();
    t_kind3_ignored();
    idle(5);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule